// File: doc/BRIEF.md
# Prescaled Time-Base Timer

A free-running time base for a small processor core. Each instruction-cycle strobe advances a hidden 2-bit prescaler. Every fourth strobe advances a visible 8-bit count. Together they form a 10-bit timer.

Software can write a preset into the visible count. That write also zeroes the hidden prescaler, so the time from the write to the next wrap is exact. A preset of 0xFF gives a wrap after 4 strobes. A preset of 0x00 gives a wrap after 1024 strobes. A wrap of the count from 0xFF to 0x00 sets a sticky overflow flag, which software polls and then clears. A halt controller can freeze the whole block through a run enable.

Top module: `tbt_timer`

## Requirements
- R1: After reset, the count and the overflow flag are zero and the prescaler is zero. The first count increment happens on the 4th accepted strobe.
- R2: While running with no load, the count increments by one on every 4th cycle that has `cyc_en_i` high. Cycles with `cyc_en_i` low do not change the count or the prescaler.
- R3: With `run_i` high, a load makes `count_o` equal to `load_val_i` on the next cycle and zeroes the prescaler. The next increment then needs 4 further strobes.
- R4: A load in the same cycle as a prescaler terminal strobe takes the loaded value. No increment is applied and no overflow is raised.
- R5: When the count wraps from 0xFF to 0x00 by increment, `ovf_o` is high in the same cycle that `count_o` first shows 0x00.
- R6: `ovf_o` stays high until `ovf_clr_i` is applied while running. It is low on the cycle after the clear.
- R7: If a clear and a new overflow occur in the same cycle, the flag stays set.
- R8: While `run_i` is low, the count, the prescaler and the flag hold. Strobes, loads and clears are ignored.
- R9: A preset V followed only by strobes sets the flag on exactly the 4*(256-V)th strobe. This gives 4 strobes for V=0xFF and 1024 strobes for V=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enable from the halt controller; low freezes all state |
| cyc_en_i | input | 1 | Instruction-cycle strobe |
| load_i | input | 1 | Preset strobe for the count |
| load_val_i | input | 8 | Preset value |
| ovf_clr_i | input | 1 | Overflow flag clear |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check the following on every cycle:
- freezing while halted;
- load value capture;
- the count moving by at most one step, and only on a strobe;
- flag stickiness;
- flag setting on a wrap, and no other way;
- clear behaviour when no wrap is possible.

The exact divide-by-4 spacing depends on hidden prescaler state, so only the bench's scenarios can show it. The same holds for the prescaler reset by a load, the load-versus-terminal-strobe collision, the set-over-clear priority and the full 4 and 1024 strobe timeouts.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_INC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int unsigned PRE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic step_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PreMax = '1;

  logic [PRE_W-1:0] pre_q;

  // terminal strobe, suppressed when a preset clears the prescaler
  assign tick_o = en_i && step_i && !clr_i && (pre_q == PreMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (en_i) begin
      if (clr_i)       pre_q <= '0;
      else if (step_i) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter
  import tbt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;
  assign wrap_o  = (op_i == CNT_INC) && (cnt_q == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_LOAD: cnt_q <= load_val_i;
        CNT_INC:  cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tbt_ovf_flag.sv
module tbt_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  assign flag_o = flag_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (en_i) begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
  import tbt_pkg::*;
#(
  parameter int unsigned PRE_W = 2,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cyc_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic    tick;
  logic    wrap;
  cnt_op_e cnt_op;

  tbt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_i),
    .clr_i  (load_i),
    .step_i (cyc_en_i),
    .tick_o (tick)
  );

  always_comb begin
    if (!run_i)      cnt_op = CNT_HOLD;
    else if (load_i) cnt_op = CNT_LOAD;
    else if (tick)   cnt_op = CNT_INC;
    else             cnt_op = CNT_HOLD;
  end

  tbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (cnt_op),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .wrap_o     (wrap)
  );

  tbt_ovf_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_i),
    .set_i  (wrap),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_o)
  );
endmodule

// File: rtl/tbt_timer_chk.sv
module tbt_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cyc_en_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(count_o) && $stable(ovf_o))); // R8

  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && load_i) |=> (count_o == $past(load_val_i))); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R2

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !cyc_en_i) |=> $stable(count_o)); // R2

  AST_WRAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && count_o == CntMax) |=> (count_o == CntMax || ovf_o)); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !(run_i && !load_i && cyc_en_i && count_o == CntMax)) |=> !ovf_o); // R5

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R6

  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && ovf_clr_i && count_o != CntMax) |=> !ovf_o); // R6
endmodule

bind tbt_timer tbt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .cyc_en_i   (cyc_en_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .ovf_clr_i  (ovf_clr_i),
  .count_o    (count_o),
  .ovf_o      (ovf_o)
);

// File: tb/tbt_timer_tb.sv
`timescale 1ns/1ps
module tbt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b1;
  logic       cyc_en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_val_i = 8'h00;
  logic       ovf_clr_i = 1'b0;
  logic [7:0] count_o;
  logic       ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [8:0] q_exp[$];
  string      q_tag[$];

  logic [1:0] m_pre = 2'd0;
  logic [7:0] m_cnt = 8'h00;
  logic       m_ovf = 1'b0;

  always #10 clk = ~clk;

  tbt_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .cyc_en_i(cyc_en_i),
    .load_i(load_i), .load_val_i(load_val_i), .ovf_clr_i(ovf_clr_i),
    .count_o(count_o), .ovf_o(ovf_o)
  );

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got cnt=%02h ovf=%0b, expected cnt=%02h ovf=%0b",
               tag, act[7:0], act[8], exp[7:0], exp[8]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic run, input logic cyc, input logic ld,
                      input logic [7:0] val, input logic clr, input string tag);
    logic evt;
    @(negedge clk);
    run_i = run; cyc_en_i = cyc; load_i = ld; load_val_i = val; ovf_clr_i = clr;
    evt = 1'b0;
    if (run) begin
      if (ld) begin
        m_cnt = val; m_pre = 2'd0;
      end else if (cyc) begin
        if (m_pre == 2'd3) begin
          if (m_cnt == 8'hFF) evt = 1'b1;
          m_cnt = m_cnt + 8'd1;
        end
        m_pre = m_pre + 2'd1;
      end
      if (evt) m_ovf = 1'b1;
      else if (clr) m_ovf = 1'b0;
    end
    q_exp.push_back({m_ovf, m_cnt});
    q_tag.push_back(tag);
  endtask

  task automatic strobes(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) check({ovf_o, count_o}, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ovf_o, count_o}, 9'h000, "R1 reset");
    rst_ni = 1'b1;
    // R1 / R2: divide-by-4 from reset, idle gaps do not advance
    strobes(3, "R1 prescale");
    step(1, 0, 0, 8'h00, 0, "R2 gap");
    step(1, 0, 0, 8'h00, 0, "R2 gap");
    strobes(1, "R1 first tick");
    strobes(8, "R2 count");
    // R3: load mid-prescale resets prescaler
    strobes(2, "R3 pre");
    step(1, 0, 1, 8'h10, 0, "R3 load");
    strobes(4, "R3 after load");
    // R4: load collides with terminal strobe
    strobes(3, "R4 pre");
    step(1, 1, 1, 8'h55, 0, "R4 collide");
    step(1, 0, 1, 8'hFF, 0, "R4 load ff");
    strobes(3, "R4 pre ff");
    step(1, 1, 1, 8'hFF, 0, "R4 collide at ff");
    step(1, 0, 0, 8'h00, 0, "R4 no ovf");
    // R5 / R9: shortest timeout
    strobes(4, "R9 timeout 4");
    step(1, 0, 0, 8'h00, 0, "R5 wrap");
    // R6 sticky then clear
    strobes(6, "R6 sticky");
    step(1, 0, 0, 8'h00, 1, "R6 clear");
    step(1, 0, 0, 8'h00, 0, "R6 cleared");
    // R7: set beats clear
    step(1, 0, 1, 8'hFF, 0, "R7 load");
    strobes(3, "R7 pre");
    step(1, 1, 0, 8'h00, 1, "R7 set vs clear");
    step(1, 0, 0, 8'h00, 0, "R7 held");
    // R8: halted, everything ignored
    step(0, 1, 0, 8'h00, 1, "R8 clear ignored");
    step(0, 1, 1, 8'hAA, 0, "R8 load ignored");
    step(0, 1, 0, 8'h00, 0, "R8 strobe ignored");
    step(0, 1, 0, 8'h00, 0, "R8 strobe ignored");
    step(1, 0, 0, 8'h00, 1, "R8 resume clear");
    step(1, 0, 1, 8'h40, 0, "R8 load");
    strobes(2, "R8 pre");
    step(0, 1, 0, 8'h00, 0, "R8 frozen pre");
    step(0, 1, 0, 8'h00, 0, "R8 frozen pre");
    strobes(2, "R8 pre resumes");
    // R9: longest timeout
    step(1, 0, 1, 8'h00, 0, "R9 load 00");
    strobes(1023, "R9 timeout 1024");
    strobes(1, "R9 wrap 1024");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule